// File: doc/BRIEF.md
# Program Status Register Unit

This block keeps the processor's current status word together with one saved status word for each of the five exception modes. The current word holds four condition flags, a sticky saturation flag, the two interrupt mask bits, the instruction-state bit and a five-bit mode code. Each cycle it can take the outcome of an ALU operation and refresh the condition flags according to the operation class. It can also perform the status part of taking an exception or returning from one, or accept a direct write of either word.

On exception entry the current word is saved in the target mode's slot. The mode code is then switched, the instruction-state bit is cleared and the interrupt masks are raised. On return the saved slot of the current mode is copied back into the current word. User and system modes share the unprivileged status and own no saved slot. All outputs come straight from registers, so the saved word shown on `spsr_o` always belongs to the mode shown in `cpsr_o` on the same cycle.

Top module: `psr_unit`

## Requirements
- R1: Bits 26:8 of both words are always zero. `irq_mask_o` equals bit 7 of the current word and `fiq_mask_o` equals bit 6. The fields sit at N=31, Z=30, C=29, V=28, Q=27, I=7, F=6, T=5 and mode=4:0.
- R2: After synchronous reset the current word is 32'h000000D3 (supervisor mode 5'b10011, I=1, F=1, all flags 0). Every saved word is zero.
- R3: With `flag_en_i` high, N takes the top bit of `alu_res_i` and Z is 1 exactly when `alu_res_i` is zero, for every operation class.
- R4: The class codes are 0 add, 1 subtract, 2 logic/shift and 3 other. C takes `alu_cout_i` for add. For subtract, where `alu_cout_i` reports a borrow, C takes its inverse. For logic/shift C takes `shift_cout_i`, and for the other class C is unchanged.
- R5: V takes `alu_ovf_i` for the add and subtract classes and is unchanged for the logic and other classes.
- R6: Q is sticky. `sat_i` sets it, and flag updates and exception entry keep it. It changes to 0 only through a current-word write or a return that loads a saved word with Q clear.
- R7: An exception request with target fast-interrupt (5'b10001), interrupt (5'b10010), supervisor (5'b10011), abort (5'b10111) or undefined (5'b11011) does four things. It copies the old current word into that mode's saved slot. It sets the mode to the target and clears T. It sets I. It sets F only when the target is fast-interrupt, and otherwise F keeps its old value. The flags are kept.
- R8: An exception request whose target is not one of the five exception modes is ignored.
- R9: `restore_i` copies the saved word of the current mode into the current word. In user (5'b10000) or system (5'b11111) mode it has no effect.
- R10: In user or system mode `spsr_o` reads zero and `spsr_we_i` is ignored. In an exception mode `spsr_we_i` writes that mode's slot.
- R11: `cpsr_we_i` loads the current word from `cpsr_wdata_i`, with bits 26:8 forced to zero. If the written mode code is none of the seven defined codes, the mode field keeps its old value.
- R12: Priority within one cycle is exception entry, then return, then current-word write, then flag update and saturation. An accepted exception entry discards a saved-word write issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| alu_res_i | input | XLEN | ALU result |
| alu_cout_i | input | 1 | Adder carry (add) or borrow (subtract) |
| alu_ovf_i | input | 1 | Signed overflow of add/subtract |
| shift_cout_i | input | 1 | Last bit shifted out |
| op_cls_i | input | 2 | Operation class: 0 add, 1 sub, 2 logic/shift, 3 other |
| flag_en_i | input | 1 | Update condition flags |
| sat_i | input | 1 | Saturation event, sets Q |
| exc_req_i | input | 1 | Exception entry request |
| exc_mode_i | input | 5 | Target mode code of the exception |
| restore_i | input | 1 | Return from exception |
| cpsr_we_i | input | 1 | Current word write strobe |
| cpsr_wdata_i | input | 32 | Current word write data |
| spsr_we_i | input | 1 | Saved word write strobe (current mode's slot) |
| spsr_wdata_i | input | 32 | Saved word write data |
| cpsr_o | output | 32 | Current status word |
| spsr_o | output | 32 | Saved word of the current mode, zero in user/system |
| irq_mask_o | output | 1 | Interrupt mask (I) |
| fiq_mask_o | output | 1 | Fast interrupt mask (F) |

## Verification
The bench builds the unit with the default XLEN of 32. At that width a single random draw can hit the sign bit, and a forced zero result makes Z reachable. Random modes in the write data reach all seven defined codes and undefined codes as well, so every saved slot and the mode-keeping rule are exercised. Overlapping requests in one cycle are drawn often enough to reach each rung of the priority order.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int PSR_W  = 32;
  localparam int NBANK  = 5;
  localparam int BIDX_W = $clog2(NBANK);

  localparam int POS_N = 31;
  localparam int POS_Z = 30;
  localparam int POS_C = 29;
  localparam int POS_V = 28;
  localparam int POS_Q = 27;
  localparam int POS_I = 7;
  localparam int POS_F = 6;
  localparam int POS_T = 5;

  localparam logic [PSR_W-1:0] KEEP_MASK = 32'hF800_00FF;

  localparam logic [4:0] MD_USER  = 5'b10000;
  localparam logic [4:0] MD_FAST  = 5'b10001;
  localparam logic [4:0] MD_IRQ   = 5'b10010;
  localparam logic [4:0] MD_SUPV  = 5'b10011;
  localparam logic [4:0] MD_ABRT  = 5'b10111;
  localparam logic [4:0] MD_UNDEF = 5'b11011;
  localparam logic [4:0] MD_SYS   = 5'b11111;

  localparam logic [PSR_W-1:0] RESET_WORD = 32'h0000_00D3;

  typedef enum logic [1:0] {
    OPC_ADD   = 2'd0,
    OPC_SUB   = 2'd1,
    OPC_LOGIC = 2'd2,
    OPC_OTHER = 2'd3
  } opc_e;

  function automatic logic [PSR_W-1:0] psr_clean(input logic [PSR_W-1:0] w);
    return w & KEEP_MASK;
  endfunction
endpackage

// File: rtl/psr_mode_decode.sv
module psr_mode_decode
  import psr_pkg::*;
(
  input  logic [4:0]        mode_i,
  output logic              legal_o,
  output logic              banked_o,
  output logic [BIDX_W-1:0] idx_o
);
  always_comb begin
    legal_o  = 1'b1;
    banked_o = 1'b1;
    idx_o    = '0;
    case (mode_i)
      MD_FAST:  idx_o = BIDX_W'(0);
      MD_IRQ:   idx_o = BIDX_W'(1);
      MD_SUPV:  idx_o = BIDX_W'(2);
      MD_ABRT:  idx_o = BIDX_W'(3);
      MD_UNDEF: idx_o = BIDX_W'(4);
      MD_USER, MD_SYS: banked_o = 1'b0;
      default: begin
        legal_o  = 1'b0;
        banked_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/psr_flag_gen.sv
module psr_flag_gen
  import psr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] res_i,
  input  logic            cout_i,
  input  logic            ovf_i,
  input  logic            sh_cout_i,
  input  logic [1:0]      op_i,
  input  logic [3:0]      nzcv_old_i,
  output logic [3:0]      nzcv_o
);
  opc_e op;
  logic n_new, z_new, c_new, v_new;

  assign op = opc_e'(op_i);

  always_comb begin
    n_new = res_i[XLEN-1];
    z_new = (res_i == '0);
    c_new = nzcv_old_i[1];
    v_new = nzcv_old_i[0];
    unique case (op)
      OPC_ADD: begin
        c_new = cout_i;
        v_new = ovf_i;
      end
      OPC_SUB: begin
        c_new = ~cout_i;
        v_new = ovf_i;
      end
      OPC_LOGIC: c_new = sh_cout_i;
      default: ;
    endcase
    nzcv_o = {n_new, z_new, c_new, v_new};
  end
endmodule

// File: rtl/psr_bank_file.sv
module psr_bank_file #(
  parameter int NBANK = 5,
  parameter int W     = 32,
  localparam int IDX_W = $clog2(NBANK)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [IDX_W-1:0] ridx_i,
  input  logic             rvalid_i,
  output logic [W-1:0]     rdata_o
);
  logic [W-1:0] bank_q [NBANK];
  logic [W-1:0] bank_d [NBANK];
  logic [W-1:0] rd_sel;

  for (genvar g = 0; g < NBANK; g++) begin : g_slot
    assign bank_d[g] = (we_i && (widx_i == IDX_W'(g))) ? wdata_i : bank_q[g];
    always_ff @(posedge clk_i) begin
      if (rst_i) bank_q[g] <= '0;
      else       bank_q[g] <= bank_d[g];
    end
  end

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NBANK; i++) begin
      if (ridx_i == IDX_W'(i)) rd_sel = bank_d[i];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)         rdata_o <= '0;
    else if (rvalid_i) rdata_o <= rd_sel;
    else               rdata_o <= '0;
  end
endmodule

// File: rtl/psr_unit.sv
module psr_unit
  import psr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [XLEN-1:0]  alu_res_i,
  input  logic             alu_cout_i,
  input  logic             alu_ovf_i,
  input  logic             shift_cout_i,
  input  logic [1:0]       op_cls_i,
  input  logic             flag_en_i,
  input  logic             sat_i,
  input  logic             exc_req_i,
  input  logic [4:0]       exc_mode_i,
  input  logic             restore_i,
  input  logic             cpsr_we_i,
  input  logic [PSR_W-1:0] cpsr_wdata_i,
  input  logic             spsr_we_i,
  input  logic [PSR_W-1:0] spsr_wdata_i,
  output logic [PSR_W-1:0] cpsr_o,
  output logic [PSR_W-1:0] spsr_o,
  output logic             irq_mask_o,
  output logic             fiq_mask_o
);
  logic [PSR_W-1:0]  cpsr_q, cpsr_d, spsr_q;
  logic [3:0]        nzcv_new;
  logic              cur_legal, cur_banked;
  logic              tgt_legal, tgt_banked;
  logic              wr_legal,  wr_banked;
  logic              nxt_legal, nxt_banked;
  logic [BIDX_W-1:0] cur_idx, tgt_idx, wr_idx, nxt_idx;
  logic              entry_ok, restore_ok;
  logic              bk_we;
  logic [BIDX_W-1:0] bk_idx;
  logic [PSR_W-1:0]  bk_data;

  psr_mode_decode u_dec_cur (.mode_i(cpsr_q[4:0]),       .legal_o(cur_legal), .banked_o(cur_banked), .idx_o(cur_idx));
  psr_mode_decode u_dec_tgt (.mode_i(exc_mode_i),        .legal_o(tgt_legal), .banked_o(tgt_banked), .idx_o(tgt_idx));
  psr_mode_decode u_dec_wr  (.mode_i(cpsr_wdata_i[4:0]), .legal_o(wr_legal),  .banked_o(wr_banked),  .idx_o(wr_idx));
  psr_mode_decode u_dec_nxt (.mode_i(cpsr_d[4:0]),       .legal_o(nxt_legal), .banked_o(nxt_banked), .idx_o(nxt_idx));

  psr_flag_gen #(.XLEN(XLEN)) u_flags (
    .res_i      (alu_res_i),
    .cout_i     (alu_cout_i),
    .ovf_i      (alu_ovf_i),
    .sh_cout_i  (shift_cout_i),
    .op_i       (op_cls_i),
    .nzcv_old_i (cpsr_q[POS_N:POS_V]),
    .nzcv_o     (nzcv_new)
  );

  assign entry_ok   = exc_req_i && tgt_banked;
  assign restore_ok = restore_i && cur_banked;

  always_comb begin
    cpsr_d = cpsr_q;
    if (entry_ok) begin
      cpsr_d[4:0]  = exc_mode_i;
      cpsr_d[POS_T] = 1'b0;
      cpsr_d[POS_I] = 1'b1;
      if (exc_mode_i == MD_FAST) cpsr_d[POS_F] = 1'b1;
    end else if (restore_ok) begin
      cpsr_d = spsr_q;
    end else if (cpsr_we_i) begin
      cpsr_d = psr_clean(cpsr_wdata_i);
      if (!wr_legal) cpsr_d[4:0] = cpsr_q[4:0];
    end else begin
      if (flag_en_i) cpsr_d[POS_N:POS_V] = nzcv_new;
      if (sat_i)     cpsr_d[POS_Q] = 1'b1;
    end
  end

  always_comb begin
    bk_we   = 1'b0;
    bk_idx  = cur_idx;
    bk_data = psr_clean(spsr_wdata_i);
    if (entry_ok) begin
      bk_we   = 1'b1;
      bk_idx  = tgt_idx;
      bk_data = cpsr_q;
    end else if (spsr_we_i && cur_banked) begin
      bk_we = 1'b1;
    end
  end

  psr_bank_file #(.NBANK(NBANK), .W(PSR_W)) u_bank (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .we_i     (bk_we),
    .widx_i   (bk_idx),
    .wdata_i  (bk_data),
    .ridx_i   (nxt_idx),
    .rvalid_i (nxt_banked),
    .rdata_o  (spsr_q)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) cpsr_q <= RESET_WORD;
    else       cpsr_q <= cpsr_d;
  end

  assign cpsr_o     = cpsr_q;
  assign spsr_o     = spsr_q;
  assign irq_mask_o = cpsr_q[POS_I];
  assign fiq_mask_o = cpsr_q[POS_F];

  // R1
  resv_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (cpsr_q[26:8] == '0) && (spsr_q[26:8] == '0));

  // R7
  entry_mode_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    entry_ok |=> (cpsr_q[4:0] == $past(exc_mode_i)) && cpsr_q[POS_I] && !cpsr_q[POS_T]);

  // R7
  entry_save_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    entry_ok |=> (spsr_q == $past(cpsr_q)));

  // R6
  q_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (cpsr_q[POS_Q] && !cpsr_we_i && !restore_ok) |=> cpsr_q[POS_Q]);

  // R10
  unbanked_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !cur_banked |-> (spsr_q == '0));

  // R8
  bad_target_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (exc_req_i && !tgt_banked && !restore_ok && !cpsr_we_i && !flag_en_i && !sat_i)
      |=> $stable(cpsr_q));
endmodule

// File: tb/psr_unit_tb.sv
module psr_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN       = 32;
  localparam logic [31:0] KMASK = 32'hF800_00FF;

  logic clk = 1'b0, rst;
  logic [XLEN-1:0] alu_res;
  logic alu_cout, alu_ovf, sh_cout, flag_en, sat, exc_req, restore, cpsr_we, spsr_we;
  logic [1:0]  op_cls;
  logic [4:0]  exc_mode;
  logic [31:0] cpsr_wdata, spsr_wdata, cpsr_o, spsr_o;
  logic irq_mask, fiq_mask;

  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_cpsr;
  logic [31:0] exp_sv [5];
  string cur_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  psr_unit #(.XLEN(XLEN)) u_dut (
    .clk_i(clk), .rst_i(rst), .alu_res_i(alu_res), .alu_cout_i(alu_cout),
    .alu_ovf_i(alu_ovf), .shift_cout_i(sh_cout), .op_cls_i(op_cls),
    .flag_en_i(flag_en), .sat_i(sat), .exc_req_i(exc_req), .exc_mode_i(exc_mode),
    .restore_i(restore), .cpsr_we_i(cpsr_we), .cpsr_wdata_i(cpsr_wdata),
    .spsr_we_i(spsr_we), .spsr_wdata_i(spsr_wdata), .cpsr_o(cpsr_o),
    .spsr_o(spsr_o), .irq_mask_o(irq_mask), .fiq_mask_o(fiq_mask)
  );

  function automatic int slot_of(input logic [4:0] m);
    case (m)
      5'b10001: return 0;
      5'b10010: return 1;
      5'b10011: return 2;
      5'b10111: return 3;
      5'b11011: return 4;
      default:  return -1;
    endcase
  endfunction

  function automatic bit defined_mode(input logic [4:0] m);
    return (slot_of(m) >= 0) || (m == 5'b10000) || (m == 5'b11111);
  endfunction

  function automatic logic [4:0] pick_mode(input int k);
    case (k % 8)
      0: return 5'b10000;
      1: return 5'b10001;
      2: return 5'b10010;
      3: return 5'b10011;
      4: return 5'b10111;
      5: return 5'b11011;
      6: return 5'b11111;
      default: return 5'($urandom);
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    alu_res = '0; alu_cout = 0; alu_ovf = 0; sh_cout = 0; op_cls = 2'd3;
    flag_en = 0; sat = 0; exc_req = 0; exc_mode = 5'b10000; restore = 0;
    cpsr_we = 0; cpsr_wdata = '0; spsr_we = 0; spsr_wdata = '0;
  endtask

  task automatic model_step();
    logic [31:0] nc;
    logic [31:0] ns [5];
    int cs, ts;
    nc = exp_cpsr;
    for (int i = 0; i < 5; i++) ns[i] = exp_sv[i];
    cs = slot_of(exp_cpsr[4:0]);
    ts = slot_of(exc_mode);
    if (exc_req && ts >= 0) begin
      ns[ts] = exp_cpsr;
      nc[4:0] = exc_mode; nc[5] = 0; nc[7] = 1;
      if (exc_mode == 5'b10001) nc[6] = 1;
    end else begin
      if (restore && cs >= 0) nc = exp_sv[cs];
      else if (cpsr_we) begin
        nc = cpsr_wdata & KMASK;
        if (!defined_mode(cpsr_wdata[4:0])) nc[4:0] = exp_cpsr[4:0];
      end else begin
        if (flag_en) begin
          nc[31] = alu_res[XLEN-1];
          nc[30] = (alu_res == '0);
          case (op_cls)
            2'd0: begin nc[29] = alu_cout;  nc[28] = alu_ovf; end
            2'd1: begin nc[29] = ~alu_cout; nc[28] = alu_ovf; end
            2'd2: nc[29] = sh_cout;
            default: ;
          endcase
        end
        if (sat) nc[27] = 1'b1;
      end
      if (spsr_we && cs >= 0) ns[cs] = spsr_wdata & KMASK;
    end
    exp_cpsr = nc;
    for (int i = 0; i < 5; i++) exp_sv[i] = ns[i];
  endtask

  task automatic compare(input string tag);
    int s;
    s = slot_of(exp_cpsr[4:0]);
    check(tag, cpsr_o, exp_cpsr);
    check((s < 0) ? "R10" : tag, spsr_o, (s < 0) ? 32'h0 : exp_sv[s]);
    check("R1", {30'd0, irq_mask, fiq_mask}, {30'd0, exp_cpsr[7], exp_cpsr[6]});
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    #1;
    model_step();
    idle();
    compare(tag);
  endtask

  task automatic flag_op(input logic [1:0] op, input logic [31:0] r,
                         input logic c, input logic v, input logic sc);
    flag_en = 1; op_cls = op; alu_res = r; alu_cout = c; alu_ovf = v; sh_cout = sc;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'hC0FFEE));
    idle();
    rst = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    exp_cpsr = 32'h0000_00D3;
    for (int i = 0; i < 5; i++) exp_sv[i] = '0;
    // R2: reset state
    check("R2", cpsr_o, 32'h0000_00D3);
    check("R2", spsr_o, 32'h0);

    // R3: zero result, negative result
    flag_op(2'd3, 32'h0, 0, 0, 0);           step("R3");
    check("R3", {30'd0, cpsr_o[31:30]}, 32'd1);
    flag_op(2'd3, 32'h8000_0001, 0, 0, 0);   step("R3");
    // R4: add carry, subtract borrow/no-borrow, shift carry, other keeps C
    flag_op(2'd0, 32'h1, 1, 0, 0);           step("R4");
    check("R4", {31'd0, cpsr_o[29]}, 32'd1);
    flag_op(2'd1, 32'h5, 1, 0, 0);           step("R4");
    check("R4", {31'd0, cpsr_o[29]}, 32'd0);
    flag_op(2'd1, 32'h5, 0, 0, 0);           step("R4");
    flag_op(2'd2, 32'h5, 1, 1, 0);           step("R4");
    flag_op(2'd3, 32'h5, 1, 1, 1);           step("R4");
    check("R4", {31'd0, cpsr_o[29]}, 32'd0);
    // R5: overflow on add, logic leaves V
    flag_op(2'd0, 32'h8000_0000, 0, 1, 0);   step("R5");
    flag_op(2'd2, 32'h1, 0, 0, 0);           step("R5");
    check("R5", {31'd0, cpsr_o[28]}, 32'd1);
    // R6: saturation sticky across flag op and entry
    sat = 1;                                 step("R6");
    flag_op(2'd0, 32'h3, 0, 0, 0);           step("R6");
    exc_req = 1; exc_mode = 5'b10010;        step("R7");
    check("R6", {31'd0, cpsr_o[27]}, 32'd1);
    // R7: fast-interrupt entry sets F
    cpsr_we = 1; cpsr_wdata = 32'h0000_0033; step("R11");
    exc_req = 1; exc_mode = 5'b10001;        step("R7");
    check("R7", {31'd0, fiq_mask}, 32'd1);
    // R9: return to saved word
    restore = 1;                             step("R9");
    // R8: bad target ignored
    exc_req = 1; exc_mode = 5'b10000;        step("R8");
    exc_req = 1; exc_mode = 5'b00101;        step("R8");
    // R10: user mode, saved write ignored, return ignored
    cpsr_we = 1; cpsr_wdata = 32'h0000_0010; step("R11");
    spsr_we = 1; spsr_wdata = 32'hFFFF_FFFF; step("R10");
    restore = 1;                             step("R9");
    check("R10", spsr_o, 32'h0);
    cpsr_we = 1; cpsr_wdata = 32'h0000_0013; step("R11");
    spsr_we = 1; spsr_wdata = 32'hFFFF_FFFF; step("R10");
    // R11: undefined mode code keeps mode
    cpsr_we = 1; cpsr_wdata = 32'hA5A5_A5A4; step("R11");
    check("R11", {27'd0, cpsr_o[4:0]}, 32'h13);
    // R12: all at once
    exc_req = 1; exc_mode = 5'b11011; restore = 1; cpsr_we = 1; cpsr_wdata = 32'h10;
    spsr_we = 1; spsr_wdata = 32'h1234_5678; flag_en = 1; sat = 1; step("R12");
    restore = 1; cpsr_we = 1; cpsr_wdata = 32'h10; flag_en = 1; step("R12");

    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      exc_req  = (r[3:0] == 0);
      exc_mode = pick_mode(int'($urandom % 8));
      restore  = ($urandom % 11) == 0;
      cpsr_we  = ($urandom % 9) == 0;
      cpsr_wdata = {$urandom} & 32'hFFFF_FFE0 | {27'd0, pick_mode(int'($urandom % 8))};
      spsr_we  = ($urandom % 7) == 0;
      spsr_wdata = $urandom;
      flag_en  = r[4];
      op_cls   = r[6:5];
      alu_res  = (r[9:7] == 0) ? '0 : $urandom;
      alu_cout = r[10]; alu_ovf = r[11]; sh_cout = r[12];
      sat      = ($urandom % 23) == 0;
      step("R12");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule